// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits on the controller side of an asynchronous dynamic memory with four byte-lane column strobes. It enforces the memory's start-up and retention rules. After reset it holds the strobes inactive through a power-up wait whose length is set in microseconds. It then runs a burst of refresh cycles to wake the array. Only after that burst does it raise `ready`.

In normal running, an interval timer clocked by the system clock raises one refresh request per row slot. The slot length is the retention period divided by the row count. Each refresh is a column-before-row cycle: all four column strobes fall together, then the row strobe follows, so address, write enable and output enable are irrelevant to it.

A single host port shares the memory bus with the sequencer. The host raises `host_req` and keeps the bus for as long as it holds the request. A refresh is started only when the host does not hold the bus. Requests that arrive while the host holds the bus are counted as pending and issued later. When the pending count reaches its limit, a fresh host request waits until one refresh has completed. If one more slot expires while the count is already at its limit, the retention deadline is treated as missed: `ready` drops and the whole wake-up burst is run again.

Top module: `drs_refresh_seq`

## Requirements
- R1: While reset is asserted and for the first PWRUP_US·CLK_KHZ/1000 clock cycles (25000 with defaults) after reset is released, `ras_n` and every `cas_n` bit stay 1 and `ready` and `host_gnt` stay 0.
- R2: After the power-up wait, exactly WAKE_CNT refresh cycles (8 with defaults) are issued, and `ready` then rises with no further cycle in between.
- R3: In each refresh cycle all four `cas_n` bits are equal at every clock. They fall CSR_C cycles (2) before `ras_n` falls, and rise CHR_C cycles (2) after `ras_n` falls.
- R4: `ras_n` stays low for exactly RAS_C cycles (5) per refresh. Between two refreshes it stays high for at least PRE_C cycles (3).
- R5: While `ready` is 1 and the host is idle, refreshes follow one another every RETAIN_US·CLK_KHZ/1000/ROWS cycles (1953 with defaults).
- R6: When `ready` is 1, no refresh is pending at its limit and the bus is free, a `host_req` at 1 is answered by `host_gnt` at 1. `host_gnt` stays 1 for as long as `host_req` stays 1.
- R7: No refresh cycle runs while `host_gnt` is 1. Every refresh interval that expires during a host hold is issued after the host releases the bus, one after another.
- R8: When MAX_PEND (4) refreshes are pending and the host asks again, exactly one refresh runs before `host_gnt` returns to 1.
- R9: If an interval expires while MAX_PEND refreshes are already pending, `ready` drops to 0. Once the bus is free, WAKE_CNT refresh cycles run and `ready` returns to 1.
- R10: `host_gnt` never rises while `ready` is 0.
- R11: `rfsh_busy` is 1 for exactly CSR_C+RAS_C+PRE_C consecutive cycles (10) per refresh cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency given by CLK_KHZ |
| rst_n | input | 1 | Active-low synchronous reset; release marks power applied |
| host_req | input | 1 | Host asks for, and then holds, the memory bus |
| host_gnt | output | 1 | Host owns the bus |
| ready | output | 1 | Power-up and wake-up are complete; memory usable |
| rfsh_busy | output | 1 | A refresh cycle is in progress; access controller must not start a cycle |
| ras_n | output | 1 | Row strobe to the memory, active low |
| cas_n | output | NCAS | Column strobes for all byte lanes, active low, driven together |

## Verification
The assertions take two things for granted: that the host drops `host_req` once it has finished, and that it never expects the strobes while it holds `host_gnt`. The strobe checks rely on `ras_n` and `cas_n` being driven only by this block. The stimulus changes `host_req` only on the falling clock edge. It starts each host hold a fixed distance after a refresh that a timer tick set off, so the bench always knows how many interval expiries fall inside the hold. Holds are released long enough before the next expiry that the post-release burst is never mixed with a new tick.

// File: rtl/drs_pkg.sv
package drs_pkg;

   typedef enum logic [1:0] {
      M_PWRUP = 2'd0,
      M_WAKE  = 2'd1,
      M_RUN   = 2'd2
   } mode_t;

   typedef enum logic [1:0] {
      P_IDLE  = 2'd0,
      P_SETUP = 2'd1,
      P_ACT   = 2'd2,
      P_PRE   = 2'd3
   } phase_t;

   // Round a duration in ns up to whole clock cycles, never below one.
   function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned clk_khz);
      longint unsigned prod;
      longint unsigned cyc;
      prod = longint'(ns) * longint'(clk_khz);
      cyc  = (prod + 64'd999999) / 64'd1000000;
      if (cyc == 0) cyc = 1;
      return int'(cyc);
   endfunction

endpackage

// File: rtl/drs_tick.sv
module drs_tick #(
   parameter int unsigned PERIOD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [W-1:0] LAST = W'(PERIOD - 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("drs_tick: PERIOD must be at least 2");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = en && (cnt == LAST);
endmodule

// File: rtl/drs_pend.sv
module drs_pend #(
   parameter int unsigned MAXP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   input  logic dec,
   output logic full,
   output logic nz,
   output logic ovf
);
   localparam int W = $clog2(MAXP + 1);
   localparam logic [W-1:0] LIM = W'(MAXP);

   if (MAXP < 1) begin : g_bad_maxp
      $error("drs_pend: MAXP must be at least 1");
   end

   logic [W-1:0] cnt;

   assign full = (cnt == LIM);
   assign nz   = (cnt != '0);
   assign ovf  = inc && full && !dec;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)               cnt <= '0;
      else if (inc && !dec && !full)   cnt <= cnt + 1'b1;
      else if (dec && !inc && nz)      cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/drs_cbr.sv
module drs_cbr
   import drs_pkg::*;
#(
   parameter int unsigned CSR_C = 2,
   parameter int unsigned CHR_C = 2,
   parameter int unsigned RAS_C = 5,
   parameter int unsigned PRE_C = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ras_n,
   output logic cas_lo_n,
   output logic busy,
   output logic done
);
   localparam int unsigned MX1 = (CSR_C > RAS_C) ? CSR_C : RAS_C;
   localparam int unsigned MXC = (MX1 > PRE_C) ? MX1 : PRE_C;
   localparam int CW = $clog2(MXC + 1);
   localparam logic [CW-1:0] CAS_REL = CW'(RAS_C - CHR_C);

   if (CHR_C >= RAS_C) begin : g_bad_hold
      $error("drs_cbr: CAS hold must end before RAS rises");
   end

   phase_t        phase;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= P_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            P_IDLE: if (start) begin
               phase <= P_SETUP;
               cnt   <= CW'(CSR_C - 1);
            end
            P_SETUP: if (cnt == '0) begin
               phase <= P_ACT;
               cnt   <= CW'(RAS_C - 1);
            end else cnt <= cnt - 1'b1;
            P_ACT: if (cnt == '0) begin
               phase <= P_PRE;
               cnt   <= CW'(PRE_C - 1);
            end else cnt <= cnt - 1'b1;
            P_PRE: if (cnt == '0) phase <= P_IDLE;
                   else cnt <= cnt - 1'b1;
            default: phase <= P_IDLE;
         endcase
      end
   end

   assign ras_n    = (phase != P_ACT);
   assign cas_lo_n = !((phase == P_SETUP) || ((phase == P_ACT) && (cnt >= CAS_REL)));
   assign busy     = (phase != P_IDLE);
   assign done     = (phase == P_PRE) && (cnt == '0);
endmodule

// File: rtl/drs_refresh_seq.sv
module drs_refresh_seq
   import drs_pkg::*;
#(
   parameter int unsigned CLK_KHZ   = 125000,
   parameter int unsigned PWRUP_US  = 200,
   parameter int unsigned WAKE_CNT  = 8,
   parameter int unsigned ROWS      = 512,
   parameter int unsigned RETAIN_US = 8000,
   parameter int unsigned TCSR_NS   = 10,
   parameter int unsigned TCHR_NS   = 10,
   parameter int unsigned TRAS_NS   = 35,
   parameter int unsigned TRP_NS    = 20,
   parameter int unsigned TRC_NS    = 60,
   parameter int unsigned MAX_PEND  = 4,
   parameter int unsigned NCAS      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_req,
   output logic            host_gnt,
   output logic            ready,
   output logic            rfsh_busy,
   output logic            ras_n,
   output logic [NCAS-1:0] cas_n
);
   localparam longint unsigned PW_L  = longint'(PWRUP_US) * longint'(CLK_KHZ) / 64'd1000;
   localparam longint unsigned IV_L  = longint'(RETAIN_US) * longint'(CLK_KHZ) / 64'd1000 / longint'(ROWS);
   localparam int unsigned PWRUP_C   = int'(PW_L);
   localparam int unsigned INTV_C    = int'(IV_L);
   localparam int unsigned CSR_C     = ns_to_clk(TCSR_NS, CLK_KHZ);
   localparam int unsigned CHR_C     = ns_to_clk(TCHR_NS, CLK_KHZ);
   localparam int unsigned RAS_C     = ns_to_clk(TRAS_NS, CLK_KHZ);
   localparam int unsigned TRC_C     = ns_to_clk(TRC_NS, CLK_KHZ);
   localparam int unsigned TRP_C     = ns_to_clk(TRP_NS, CLK_KHZ);
   localparam int unsigned PRE_C     = (TRC_C > RAS_C + TRP_C) ? (TRC_C - RAS_C) : TRP_C;
   localparam int          WW        = $clog2(WAKE_CNT + 1);

   if (WAKE_CNT < 1) begin : g_bad_wake
      $error("drs_refresh_seq: WAKE_CNT must be at least 1");
   end
   if (INTV_C < CSR_C + RAS_C + PRE_C + 2) begin : g_bad_intv
      $error("drs_refresh_seq: refresh slot shorter than one refresh cycle");
   end
   if (NCAS < 1) begin : g_bad_ncas
      $error("drs_refresh_seq: NCAS must be at least 1");
   end

   mode_t          mode;
   logic [WW-1:0]  wake_left;
   logic           pw_tick, iv_tick;
   logic           p_full, p_nz, p_ovf;
   logic           eng_start, eng_busy, eng_done, cas_lo_n;
   logic           can_issue, want_rf, gnt_set;

   drs_tick #(.PERIOD(PWRUP_C)) u_pwr (
      .clk(clk), .rst_n(rst_n), .en(mode == M_PWRUP), .tick(pw_tick)
   );

   drs_tick #(.PERIOD(INTV_C)) u_intv (
      .clk(clk), .rst_n(rst_n), .en(mode == M_RUN), .tick(iv_tick)
   );

   drs_pend #(.MAXP(MAX_PEND)) u_pend (
      .clk(clk), .rst_n(rst_n), .clr(mode != M_RUN),
      .inc(iv_tick), .dec(eng_done && (mode == M_RUN)),
      .full(p_full), .nz(p_nz), .ovf(p_ovf)
   );

   drs_cbr #(.CSR_C(CSR_C), .CHR_C(CHR_C), .RAS_C(RAS_C), .PRE_C(PRE_C)) u_cbr (
      .clk(clk), .rst_n(rst_n), .start(eng_start),
      .ras_n(ras_n), .cas_lo_n(cas_lo_n), .busy(eng_busy), .done(eng_done)
   );

   always_comb begin
      can_issue = !host_gnt && !eng_busy;
      want_rf   = p_full || (p_nz && !host_req);
      eng_start = can_issue &&
                  (((mode == M_WAKE) && (wake_left != '0)) ||
                   ((mode == M_RUN) && want_rf && !p_ovf));
      gnt_set   = can_issue && (mode == M_RUN) && !want_rf && host_req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode      <= M_PWRUP;
         wake_left <= '0;
         host_gnt  <= 1'b0;
      end else begin
         if (host_gnt && !host_req) host_gnt <= 1'b0;
         else if (gnt_set)          host_gnt <= 1'b1;

         unique case (mode)
            M_PWRUP: if (pw_tick) begin
               mode      <= M_WAKE;
               wake_left <= WW'(WAKE_CNT);
            end
            M_WAKE: begin
               if (eng_start) wake_left <= wake_left - 1'b1;
               if ((wake_left == '0) && !eng_busy) mode <= M_RUN;
            end
            M_RUN: if (p_ovf) begin
               mode      <= M_WAKE;
               wake_left <= WW'(WAKE_CNT);
            end
            default: mode <= M_PWRUP;
         endcase
      end
   end

   assign ready     = (mode == M_RUN);
   assign rfsh_busy = eng_busy;

   for (genvar i = 0; i < NCAS; i++) begin : g_cas
      assign cas_n[i] = cas_lo_n;
   end
endmodule

// File: rtl/drs_refresh_chk.sv
module drs_refresh_chk #(
   parameter int unsigned NCAS  = 4,
   parameter int unsigned RAS_C = 5,
   parameter int unsigned PRE_C = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            host_gnt,
   input logic            ready,
   input logic            rfsh_busy,
   input logic            ras_n,
   input logic [NCAS-1:0] cas_n
);
   logic [7:0] lo_run, hi_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_run <= '0;
         hi_run <= '0;
      end else begin
         lo_run <= ras_n ? 8'd0 : ((lo_run == 8'hFF) ? lo_run : lo_run + 8'd1);
         hi_run <= !ras_n ? 8'd0 : ((hi_run == 8'hFF) ? hi_run : hi_run + 8'd1);
      end
   end

   // R3
   cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (cas_n == '0));

   // R3
   cas_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_n == '0) || (cas_n == '1));

   // R4
   ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (lo_run >= 8'(RAS_C)));

   // R4
   ras_prech_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (hi_run >= 8'(PRE_C)));

   // R7
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_gnt |-> (ras_n && !rfsh_busy));

   // R10
   gnt_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_gnt) |-> ready);
endmodule

bind drs_refresh_seq drs_refresh_chk #(
   .NCAS(NCAS), .RAS_C(RAS_C), .PRE_C(PRE_C)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_gnt(host_gnt), .ready(ready),
   .rfsh_busy(rfsh_busy), .ras_n(ras_n), .cas_n(cas_n)
);

// File: tb/sim_drs_refresh_seq.sv
module sim_drs_refresh_seq;
   localparam int PWRUP_C = 25000;   // 200 us at 8 ns
   localparam int INTV_C  = 1953;    // 8 ms / 512 rows at 8 ns, rounded down
   localparam int WAKE_N  = 8;
   localparam int CSR_C   = 2;
   localparam int CHR_C   = 2;
   localparam int RAS_C   = 5;
   localparam int PRE_C   = 3;
   localparam int CYC_C   = CSR_C + RAS_C + PRE_C;

   // {intervals held, refreshes after release, ready just before release}
   localparam int TBL [4][3] = '{'{1, 1, 1}, '{2, 2, 1}, '{4, 4, 1}, '{5, 8, 0}};

   logic       clk = 1'b0;
   logic       rst_n;
   logic       host_req;
   logic       host_gnt, ready, rfsh_busy, ras_n;
   logic [3:0] cas_n;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rf_cnt = 0;
   int cas_fall = 0, ras_fall = 0, ras_rise = 0;
   bit rise_seen = 1'b0;
   int bad_r3 = 0, bad_r4 = 0, bad_ovl = 0, bad_r10 = 0;
   int run = 0, last_run = 0;
   logic p_ras = 1'b1, p_cas = 1'b1, p_gnt = 1'b0;

   always #4 clk = ~clk;

   drs_refresh_seq u0 (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_gnt(host_gnt),
      .ready(ready), .rfsh_busy(rfsh_busy), .ras_n(ras_n), .cas_n(cas_n)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if ((cas_n != 4'h0) && (cas_n != 4'hF)) bad_r3++;
         if (p_cas && !cas_n[0]) cas_fall = cyc;
         if (p_ras && !ras_n) begin
            ras_fall = cyc;
            rf_cnt++;
            if (ras_fall - cas_fall != CSR_C) bad_r3++;
            if (rise_seen && (ras_fall - ras_rise < PRE_C)) bad_r4++;
         end
         if (!p_cas && cas_n[0] && (cyc - ras_fall != CHR_C)) bad_r3++;
         if (!p_ras && ras_n) begin
            ras_rise  = cyc;
            rise_seen = 1'b1;
            if (ras_rise - ras_fall != RAS_C) bad_r4++;
         end
         if (host_gnt && (!ras_n || rfsh_busy)) bad_ovl++;
         if (!p_gnt && host_gnt && !ready) bad_r10++;
         if (rfsh_busy) run++;
         else if (run != 0) begin
            last_run = run;
            run = 0;
         end
         p_ras = ras_n;
         p_cas = cas_n[0];
         p_gnt = host_gnt;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_fall();
      int n;
      n = rf_cnt;
      while (rf_cnt == n) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_up();
   end

   initial begin
      int t0, n0, n1, f1, f2, f3, w;
      rst_n    = 1'b0;
      host_req = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(ras_n && (cas_n == 4'hF) && !ready && !host_gnt, "R1 reset",
          {ras_n, cas_n, ready, host_gnt}, 8'b1_1111_00 >> 0);
      rst_n = 1'b1;
      t0 = cyc;
      repeat (PWRUP_C - 10) @(negedge clk);
      // R1, R10: quiet during power-up even with a host request
      chk(rf_cnt == 0, "R1 no cycle during power-up", rf_cnt, 0);
      chk(!ready && !host_gnt, "R10 no grant before ready", {ready, host_gnt}, 0);
      while (!ready) @(negedge clk);
      // R2 wake burst
      chk(rf_cnt == WAKE_N, "R2 wake refresh count", rf_cnt, WAKE_N);
      chk((cyc - t0 >= PWRUP_C) && (cyc - t0 <= PWRUP_C + WAKE_N * (CYC_C + 1) + 10),
          "R2 ready time", cyc - t0, PWRUP_C);
      repeat (2) @(negedge clk);
      // R6 grant after ready
      chk(host_gnt == 1'b1, "R6 grant after ready", host_gnt, 1);
      host_req = 1'b0;

      // R5 refresh spacing with an idle host
      wait_fall(); f1 = ras_fall;
      wait_fall(); f2 = ras_fall;
      wait_fall(); f3 = ras_fall;
      chk(f2 - f1 == INTV_C, "R5 interval 1", f2 - f1, INTV_C);
      chk(f3 - f2 == INTV_C, "R5 interval 2", f3 - f2, INTV_C);

      // R6, R7, R9 host holds of various lengths
      for (int i = 0; i < 4; i++) begin
         wait_fall();
         repeat (100) @(negedge clk);
         host_req = 1'b1;
         repeat (2) @(negedge clk);
         chk(host_gnt == 1'b1, "R6 grant", host_gnt, 1);
         n0 = rf_cnt;
         repeat (TBL[i][0] * INTV_C - 2) @(negedge clk);
         chk(rf_cnt == n0, "R7 no refresh while held", rf_cnt - n0, 0);
         chk(host_gnt == 1'b1, "R6 grant kept", host_gnt, 1);
         chk(ready == TBL[i][2][0], "R9 ready during hold", ready, TBL[i][2]);
         host_req = 1'b0;
         n1 = rf_cnt;
         repeat (200) @(negedge clk);
         chk(rf_cnt - n1 == TBL[i][1], "R7/R9 refreshes after release", rf_cnt - n1, TBL[i][1]);
         chk(ready == 1'b1, "R9 ready after release", ready, 1);
      end

      // R8 pending limit blocks the next host request for one refresh
      wait_fall();
      repeat (100) @(negedge clk);
      host_req = 1'b1;
      repeat (4 * INTV_C) @(negedge clk);
      host_req = 1'b0;
      n1 = rf_cnt;
      @(negedge clk);
      host_req = 1'b1;
      w = 0;
      while (!host_gnt && w < 200) begin
         @(negedge clk);
         w++;
      end
      chk(host_gnt == 1'b1, "R8 grant returns", host_gnt, 1);
      chk(rf_cnt - n1 == 1, "R8 one refresh before grant", rf_cnt - n1, 1);
      host_req = 1'b0;
      n1 = rf_cnt;
      repeat (200) @(negedge clk);
      chk(rf_cnt - n1 == 3, "R7 remaining pending refreshes", rf_cnt - n1, 3);

      // Strobe shape gathered across the whole run
      chk(bad_r3 == 0, "R3 CAS/RAS order and lanes", bad_r3, 0);
      chk(bad_r4 == 0, "R4 RAS width and precharge", bad_r4, 0);
      chk(bad_ovl == 0, "R7 no refresh under grant", bad_ovl, 0);
      chk(bad_r10 == 0, "R10 grant only when ready", bad_r10, 0);
      chk(last_run == CYC_C, "R11 busy length", last_run, CYC_C);
      finish_up();
   end
endmodule